// File: doc/BRIEF.md
# String Port/Memory Transfer Engine

This block moves a block of equal-sized elements between a fixed address in a 16-bit port space and a run of memory locations. It is configured in one cycle with a port address, a starting memory pointer, an element count, an element size (byte, word or doubleword), a direction for the pointer and the direction of data flow. The engine then walks through the elements one at a time. For each element it makes exactly one port access and one memory access, strictly in sequence. After that it moves the pointer by the element size and lowers the count by one.

Toward the port: each element is first read from memory at the pointer and then written to the port. From the port: each element is first read from the port and then written to memory at the pointer. The port address never changes during a run. When the count is exhausted the engine pulses `done` for one cycle and presents the final pointer and the remaining count, so a caller can continue from where the run stopped. Both buses use a valid/ready handshake. Only one of the two buses carries a request at any time.

Top module: `strio_xfer_engine`

## Requirements
- R1: After reset `busy`, `done`, `port_valid` and `mem_valid` are all low.
- R2: A start accepted with a count of zero makes no bus access. It raises `done` in the cycle right after the start edge, with `cur_ptr` equal to the loaded pointer and `cur_count` equal to zero.
- R3: With `cfg_to_port` = 0, every element is a port read (`port_write` = 0) followed by a memory write (`mem_write` = 1) whose data is the port read data. Port and memory accesses alternate and a port access comes first.
- R4: With `cfg_to_port` = 1, every element is a memory read (`mem_write` = 0) at the pointer followed by a port write (`port_write` = 1) of that data. Memory comes first.
- R5: Size code 0 is byte, 1 is word, 2 is doubleword, and 3 acts as doubleword. Both buses carry the normalized code on their size field. On the write side, data bits above the element size (above bit 7 for byte, above bit 15 for word) are zero.
- R6: With `cfg_down` = 0 the pointer for element i is the start pointer plus i times the element byte count (1, 2 or 4). With `cfg_down` = 1 it is the start pointer minus that amount. Both cases wrap modulo 2^ADDR_W.
- R7: Exactly `cfg_count` elements are moved. `done` is high for exactly one cycle, the cycle after the last access completes. While `done` is high, `cur_count` is zero and `cur_ptr` is the pointer after the last element.
- R8: Every port access uses the port address that was loaded at start.
- R9: A request that is not accepted keeps its valid, address, write flag and write data unchanged until ready is seen. `port_valid` and `mem_valid` are never high together.
- R10: A start pulse while `busy` is high is ignored: the running transfer's accesses, final pointer and count are unchanged, and no new run begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load configuration and begin, honoured only when idle |
| cfg_port | input | PORT_W | Port address used for the whole run |
| cfg_ptr | input | ADDR_W | Starting memory byte address |
| cfg_count | input | CNT_W | Number of elements |
| cfg_size | input | 2 | Element size code: 0 byte, 1 word, 2 or 3 doubleword |
| cfg_down | input | 1 | 1: pointer decrements, 0: pointer increments |
| cfg_to_port | input | 1 | 1: memory to port, 0: port to memory |
| busy | output | 1 | Run in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| cur_ptr | output | ADDR_W | Working memory pointer |
| cur_count | output | CNT_W | Remaining element count |
| port_valid | output | 1 | Port request valid |
| port_write | output | 1 | Port request is a write |
| port_addr | output | PORT_W | Port address |
| port_size | output | 2 | Normalized element size code |
| port_wdata | output | DATA_W | Port write data |
| port_ready | input | 1 | Port accepts request / read data valid |
| port_rdata | input | DATA_W | Port read data |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_size | output | 2 | Normalized element size code |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory accepts request / read data valid |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The bench builds the engine with ADDR_W = 12, CNT_W = 8, DATA_W = 32 and PORT_W = 16. The narrow pointer lets a short decrementing run starting near address zero wrap to the top of the space, so modulo arithmetic is exercised without long transfers. The 8-bit count keeps every run to a handful of elements. The bench buses return junk in the byte lanes above the element size, so zero-filling on the write side is visible at the ports. A stall mode toggles both ready inputs so that requests have to wait and be held.

// File: rtl/strio_pkg.sv
package strio_pkg;

   typedef enum logic [1:0] {
      ESZ_BYTE = 2'd0,
      ESZ_HALF = 2'd1,
      ESZ_FULL = 2'd2,
      ESZ_RSVD = 2'd3
   } esz_e;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LAUNCH = 3'd1,
      ST_FIRST  = 3'd2,
      ST_SECOND = 3'd3,
      ST_DONE   = 3'd4
   } xst_e;

   // The reserved code behaves as the widest element.
   function automatic esz_e esz_norm(input logic [1:0] raw);
      case (raw)
         2'd0:    return ESZ_BYTE;
         2'd1:    return ESZ_HALF;
         default: return ESZ_FULL;
      endcase
   endfunction

   function automatic logic [2:0] esz_bytes(input esz_e sz);
      case (sz)
         ESZ_BYTE: return 3'd1;
         ESZ_HALF: return 3'd2;
         default:  return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/strio_lane_mask.sv
module strio_lane_mask
   import strio_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] din,
   input  esz_e              sz,
   output logic [DATA_W-1:0] dout
);

   localparam int LANES = DATA_W / 8;

   if (DATA_W % 8 != 0 || DATA_W < 32) begin : g_bad_width
      $error("strio_lane_mask: DATA_W must be a multiple of 8 and at least 32");
   end

   logic [2:0] keep_n;
   assign keep_n = esz_bytes(sz);

   // Each byte lane is kept only when it lies inside the element.
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign dout[g*8 +: 8] = (int'(keep_n) > g) ? din[g*8 +: 8] : 8'h00;
   end

endmodule

// File: rtl/strio_bus_chan.sv
module strio_bus_chan
   import strio_pkg::*;
#(
   parameter int AW     = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [AW-1:0]     issue_addr,
   input  logic              issue_write,
   input  logic [DATA_W-1:0] issue_wdata,
   input  esz_e              issue_size,
   output logic              bus_valid,
   output logic [AW-1:0]     bus_addr,
   output logic              bus_write,
   output logic [1:0]        bus_size,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ready,
   output logic              fire
);

   if (AW < 1) begin : g_bad_aw
      $error("strio_bus_chan: AW must be positive");
   end

   assign fire = bus_valid && bus_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_valid <= 1'b0;
         bus_addr  <= '0;
         bus_write <= 1'b0;
         bus_size  <= 2'd0;
         bus_wdata <= '0;
      end else if (issue) begin
         bus_valid <= 1'b1;
         bus_addr  <= issue_addr;
         bus_write <= issue_write;
         bus_size  <= issue_size;
         bus_wdata <= issue_wdata;
      end else if (fire) begin
         bus_valid <= 1'b0;
      end
   end

   // R9
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
                                  $stable(bus_write) && $stable(bus_wdata));

   // R9
   issue_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> !bus_valid);

endmodule

// File: rtl/strio_ptr_unit.sv
module strio_ptr_unit
   import strio_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_ptr,
   input  logic [CNT_W-1:0]  load_cnt,
   input  logic              load_down,
   input  esz_e              load_size,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr,
   output logic [CNT_W-1:0]  cnt,
   output logic              down,
   output esz_e              size,
   output logic              last
);

   localparam int PAD_W = ADDR_W - 3;

   if (ADDR_W < 4) begin : g_bad_aw
      $error("strio_ptr_unit: ADDR_W must be at least 4");
   end
   if (CNT_W < 1) begin : g_bad_cw
      $error("strio_ptr_unit: CNT_W must be positive");
   end

   logic [ADDR_W-1:0] delta;
   logic [ADDR_W-1:0] ptr_nxt;

   assign delta   = {{PAD_W{1'b0}}, esz_bytes(size)};
   assign ptr_nxt = down ? (ptr - delta) : (ptr + delta);
   assign last    = (cnt == {{(CNT_W-1){1'b0}}, 1'b1});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr  <= '0;
         cnt  <= '0;
         down <= 1'b0;
         size <= ESZ_BYTE;
      end else if (load) begin
         ptr  <= load_ptr;
         cnt  <= load_cnt;
         down <= load_down;
         size <= load_size;
      end else if (step) begin
         ptr <= ptr_nxt;
         cnt <= cnt - 1'b1;
      end
   end

   // R7
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step && !load |=> cnt == $past(cnt) - 1'b1);

   // R7
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> cnt != '0);

   // R6
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step && !load |=> $stable(ptr) && $stable(cnt));

endmodule

// File: rtl/strio_xfer_engine.sv
module strio_xfer_engine
   import strio_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int PORT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PORT_W-1:0] cfg_port,
   input  logic [ADDR_W-1:0] cfg_ptr,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic [1:0]        cfg_size,
   input  logic              cfg_down,
   input  logic              cfg_to_port,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] cur_ptr,
   output logic [CNT_W-1:0]  cur_count,
   output logic              port_valid,
   output logic              port_write,
   output logic [PORT_W-1:0] port_addr,
   output logic [1:0]        port_size,
   output logic [DATA_W-1:0] port_wdata,
   input  logic              port_ready,
   input  logic [DATA_W-1:0] port_rdata,
   output logic              mem_valid,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata
);

   if (PORT_W < 1 || PORT_W > 32) begin : g_bad_pw
      $error("strio_xfer_engine: PORT_W out of range");
   end
   if (DATA_W < 32) begin : g_bad_dw
      $error("strio_xfer_engine: DATA_W must hold a doubleword");
   end

   xst_e              state_q, state_d;
   logic [PORT_W-1:0] port_q;
   logic              to_port_q;
   logic              accept;
   logic              last_el;
   logic              dir_q;
   esz_e              sz_q;
   logic              port_fire, mem_fire;
   logic              first_fire, second_fire;
   logic              launch, handoff, step;
   logic              port_issue, mem_issue;
   logic [DATA_W-1:0] port_rd_m, mem_rd_m;

   assign accept = (state_q == ST_IDLE) && start;

   // Which bus goes first depends on the data direction.
   assign first_fire  = to_port_q ? mem_fire  : port_fire;
   assign second_fire = to_port_q ? port_fire : mem_fire;
   assign launch      = (state_q == ST_LAUNCH);
   assign handoff     = (state_q == ST_FIRST) && first_fire;
   assign step        = (state_q == ST_SECOND) && second_fire;
   assign port_issue  = to_port_q ? handoff : launch;
   assign mem_issue   = to_port_q ? launch  : handoff;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:   if (start) state_d = (cfg_count == '0) ? ST_DONE : ST_LAUNCH;
         ST_LAUNCH: state_d = ST_FIRST;
         ST_FIRST:  if (first_fire) state_d = ST_SECOND;
         ST_SECOND: if (second_fire) state_d = last_el ? ST_DONE : ST_LAUNCH;
         ST_DONE:   state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         port_q    <= '0;
         to_port_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            port_q    <= cfg_port;
            to_port_q <= cfg_to_port;
         end
      end
   end

   assign busy = (state_q != ST_IDLE);
   assign done = (state_q == ST_DONE);

   strio_ptr_unit #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_ptr  (cfg_ptr),
      .load_cnt  (cfg_count),
      .load_down (cfg_down),
      .load_size (esz_norm(cfg_size)),
      .step      (step),
      .ptr       (cur_ptr),
      .cnt       (cur_count),
      .down      (dir_q),
      .size      (sz_q),
      .last      (last_el)
   );

   strio_lane_mask #(.DATA_W(DATA_W)) u_mask_port (
      .din  (port_rdata),
      .sz   (sz_q),
      .dout (port_rd_m)
   );

   strio_lane_mask #(.DATA_W(DATA_W)) u_mask_mem (
      .din  (mem_rdata),
      .sz   (sz_q),
      .dout (mem_rd_m)
   );

   strio_bus_chan #(
      .AW     (PORT_W),
      .DATA_W (DATA_W)
   ) u_port_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue       (port_issue),
      .issue_addr  (port_q),
      .issue_write (to_port_q),
      .issue_wdata (mem_rd_m),
      .issue_size  (sz_q),
      .bus_valid   (port_valid),
      .bus_addr    (port_addr),
      .bus_write   (port_write),
      .bus_size    (port_size),
      .bus_wdata   (port_wdata),
      .bus_ready   (port_ready),
      .fire        (port_fire)
   );

   strio_bus_chan #(
      .AW     (ADDR_W),
      .DATA_W (DATA_W)
   ) u_mem_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue       (mem_issue),
      .issue_addr  (cur_ptr),
      .issue_write (!to_port_q),
      .issue_wdata (port_rd_m),
      .issue_size  (sz_q),
      .bus_valid   (mem_valid),
      .bus_addr    (mem_addr),
      .bus_write   (mem_write),
      .bus_size    (mem_size),
      .bus_wdata   (mem_wdata),
      .bus_ready   (mem_ready),
      .fire        (mem_fire)
   );

   // R9
   one_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(port_valid && mem_valid));

   // R8
   port_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_valid |-> port_addr == port_q);

   // R2
   zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && cfg_count == '0 |=> done && cur_count == '0);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   // R10
   busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> busy && $stable(port_q) && $stable(to_port_q));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !port_valid && !mem_valid);

   // R7
   done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cur_count == '0);

endmodule

// File: tb/strio_xfer_engine_tb.sv
`timescale 1ns/1ps
module strio_xfer_engine_tb;

   localparam int AW = 12;
   localparam int CW = 8;
   localparam int DW = 32;
   localparam int PW = 16;
   localparam int LOGN = 1024;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [PW-1:0] cfg_port = '0;
   logic [AW-1:0] cfg_ptr = '0;
   logic [CW-1:0] cfg_count = '0;
   logic [1:0]    cfg_size = '0;
   logic          cfg_down = 1'b0;
   logic          cfg_to_port = 1'b0;
   logic          busy, done;
   logic [AW-1:0] cur_ptr;
   logic [CW-1:0] cur_count;
   logic          port_valid, port_write, port_ready;
   logic [PW-1:0] port_addr;
   logic [1:0]    port_size, mem_size;
   logic [DW-1:0] port_wdata, port_rdata, mem_wdata, mem_rdata;
   logic          mem_valid, mem_write, mem_ready;
   logic [AW-1:0] mem_addr;

   always #4 clk = ~clk;

   strio_xfer_engine #(
      .ADDR_W (AW), .CNT_W (CW), .DATA_W (DW), .PORT_W (PW)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .start (start),
      .cfg_port (cfg_port), .cfg_ptr (cfg_ptr), .cfg_count (cfg_count),
      .cfg_size (cfg_size), .cfg_down (cfg_down), .cfg_to_port (cfg_to_port),
      .busy (busy), .done (done), .cur_ptr (cur_ptr), .cur_count (cur_count),
      .port_valid (port_valid), .port_write (port_write), .port_addr (port_addr),
      .port_size (port_size), .port_wdata (port_wdata), .port_ready (port_ready),
      .port_rdata (port_rdata),
      .mem_valid (mem_valid), .mem_write (mem_write), .mem_addr (mem_addr),
      .mem_size (mem_size), .mem_wdata (mem_wdata), .mem_ready (mem_ready),
      .mem_rdata (mem_rdata)
   );

   // Bus models: byte pattern per memory address, sequence-based port data.
   function automatic logic [7:0] bpat(input logic [AW-1:0] a);
      return a[7:0] ^ {a[11:8], 4'h9};
   endfunction

   function automatic logic [31:0] mpat(input logic [AW-1:0] a);
      return {bpat(a + 12'd3), bpat(a + 12'd2), bpat(a + 12'd1), bpat(a)};
   endfunction

   function automatic logic [31:0] keep(input logic [31:0] d, input logic [1:0] sz);
      case (sz)
         2'd0:    return d & 32'h0000_00FF;
         2'd1:    return d & 32'h0000_FFFF;
         default: return d;
      endcase
   endfunction

   logic [7:0] pseq = 8'h00;
   assign port_rdata = {pseq ^ 8'hC3, pseq ^ 8'h96, pseq ^ 8'h5A, pseq + 8'h11};
   assign mem_rdata  = mpat(mem_addr);

   logic stall = 1'b0;
   int   cyc = 0;
   logic p_rdy = 1'b1, m_rdy = 1'b1;
   assign port_ready = p_rdy;
   assign mem_ready  = m_rdy;

   always @(negedge clk) begin
      p_rdy <= stall ? ((cyc % 3) == 2) : 1'b1;
      m_rdy <= stall ? ((cyc % 4) == 1) : 1'b1;
   end

   // Monitor: log every accepted bus access and the done/accept events.
   logic          ev_mem   [LOGN];
   logic          ev_wr    [LOGN];
   logic [31:0]   ev_addr  [LOGN];
   logic [1:0]    ev_sz    [LOGN];
   logic [31:0]   ev_data  [LOGN];
   int            ev_cyc   [LOGN];
   int            ev_n = 0;
   int            overlap = 0;
   int            done_hits = 0;
   int            done_cyc = 0;
   logic [AW-1:0] done_ptr = '0;
   logic [CW-1:0] done_cnt = '0;
   int            acc_n = 0;
   int            acc_cyc = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (port_valid && mem_valid) overlap <= overlap + 1;
      if (port_valid && port_ready && ev_n < LOGN) begin
         ev_mem[ev_n]  <= 1'b0;
         ev_wr[ev_n]   <= port_write;
         ev_addr[ev_n] <= {16'h0, port_addr};
         ev_sz[ev_n]   <= port_size;
         ev_data[ev_n] <= port_write ? port_wdata : port_rdata;
         ev_cyc[ev_n]  <= cyc;
         ev_n <= ev_n + 1;
         if (!port_write) pseq <= pseq + 8'd1;
      end else if (mem_valid && mem_ready && ev_n < LOGN) begin
         ev_mem[ev_n]  <= 1'b1;
         ev_wr[ev_n]   <= mem_write;
         ev_addr[ev_n] <= {20'h0, mem_addr};
         ev_sz[ev_n]   <= mem_size;
         ev_data[ev_n] <= mem_write ? mem_wdata : mem_rdata;
         ev_cyc[ev_n]  <= cyc;
         ev_n <= ev_n + 1;
      end
      if (done) begin
         done_hits <= done_hits + 1;
         done_cyc  <= cyc;
         done_ptr  <= cur_ptr;
         done_cnt  <= cur_count;
      end
      if (start && !busy && rst_n) begin
         acc_n   <= acc_n + 1;
         acc_cyc <= cyc;
      end
   end

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_done(input int dh0);
      for (int k = 0; k < 3000 && done_hits == dh0; k++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", {31'd0, busy}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 done after reset", {31'd0, done}, 32'd0);
      chk("R1 valids after reset", {30'd0, port_valid, mem_valid}, 32'd0);
      chk("R1 busy after reset", {31'd0, busy}, 32'd0);
   endtask

   task automatic t_zero(input logic [AW-1:0] ptr);
      int base, dh0;
      base = ev_n; dh0 = done_hits;
      cfg_ptr = ptr; cfg_count = '0; cfg_size = 2'd1; cfg_down = 1'b0;
      cfg_port = 16'h0042; cfg_to_port = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(dh0);
      chk("R2 no accesses", ev_n - base, 32'd0);
      chk("R2 done one cycle after start", done_cyc, acc_cyc + 1);
      chk("R2 final ptr", {20'd0, done_ptr}, {20'd0, ptr});
      chk("R2 final count", {24'd0, done_cnt}, 32'd0);
   endtask

   task automatic run_xfer(input logic to_port, input logic [1:0] sz, input logic dn,
                           input logic [AW-1:0] ptr, input logic [CW-1:0] n,
                           input logic [PW-1:0] pa, input logic stall_on,
                           input logic poke, input string tag);
      int base, dh0, an0, st;
      logic [1:0] nsz;
      logic [AW-1:0] fin;
      nsz = (sz == 2'd3) ? 2'd2 : sz;
      st = (nsz == 2'd0) ? 1 : (nsz == 2'd1) ? 2 : 4;
      stall = stall_on;
      base = ev_n; dh0 = done_hits; an0 = acc_n;
      cfg_to_port = to_port; cfg_size = sz; cfg_down = dn;
      cfg_ptr = ptr; cfg_count = n; cfg_port = pa;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         for (int k = 0; k < 200 && ev_n <= base; k++) @(negedge clk);
         cfg_count = 8'd9; cfg_down = ~dn; cfg_to_port = ~to_port;
         cfg_ptr = 12'h800; cfg_port = 16'hBEEF;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait_done(dh0);
      stall = 1'b0;
      chk({"R7 element count ", tag}, ev_n - base, 2 * int'(n));
      chk({"R7 single done ", tag}, done_hits - dh0, 32'd1);
      if (poke) chk({"R10 start while busy ignored ", tag}, acc_n - an0, 32'd1);
      if (ev_n - base == 2 * int'(n) && n != 0) begin
         for (int i = 0; i < int'(n); i++) begin
            int b0, b1;
            logic [AW-1:0] ea;
            logic [AW-1:0] off;
            b0 = base + 2 * i;
            b1 = b0 + 1;
            off = AW'(i * st);
            ea = dn ? ptr - off : ptr + off;
            chk({"R5 sizes ", tag}, {28'd0, ev_sz[b0], ev_sz[b1]}, {28'd0, nsz, nsz});
            if (!to_port) begin
               chk({"R3 port read first ", tag}, {30'd0, ev_mem[b0], ev_wr[b0]}, 32'd0);
               chk({"R8 port address ", tag}, ev_addr[b0], {16'd0, pa});
               chk({"R3 memory write second ", tag}, {30'd0, ev_mem[b1], ev_wr[b1]}, 32'd3);
               chk({"R6 memory address ", tag}, ev_addr[b1], {20'd0, ea});
               chk({"R5 masked write data ", tag}, ev_data[b1], keep(ev_data[b0], nsz));
            end else begin
               chk({"R4 memory read first ", tag}, {30'd0, ev_mem[b0], ev_wr[b0]}, 32'd2);
               chk({"R6 memory address ", tag}, ev_addr[b0], {20'd0, ea});
               chk({"R4 port write second ", tag}, {30'd0, ev_mem[b1], ev_wr[b1]}, 32'd1);
               chk({"R8 port address ", tag}, ev_addr[b1], {16'd0, pa});
               chk({"R5 masked write data ", tag}, ev_data[b1], keep(mpat(ea), nsz));
            end
         end
         chk({"R7 done after last access ", tag}, done_cyc, ev_cyc[ev_n - 1] + 1);
      end
      fin = dn ? ptr - AW'(int'(n) * st) : ptr + AW'(int'(n) * st);
      chk({"R7 final pointer ", tag}, {20'd0, done_ptr}, {20'd0, fin});
      chk({"R7 final count ", tag}, {24'd0, done_cnt}, 32'd0);
      chk({"R1 idle after done ", tag}, {31'd0, busy}, 32'd0);
   endtask

   task automatic finish_run();
      chk("R9 never both buses valid", overlap, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired R7 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_zero(12'h345);
      run_xfer(1'b0, 2'd0, 1'b0, 12'h100, 8'd5, 16'h03F8, 1'b0, 1'b0, "in byte up");
      run_xfer(1'b0, 2'd1, 1'b1, 12'h204, 8'd4, 16'hFFFF, 1'b0, 1'b0, "in word down");
      run_xfer(1'b1, 2'd2, 1'b0, 12'h3F0, 8'd3, 16'h0000, 1'b1, 1'b0, "out dword up stall");
      run_xfer(1'b1, 2'd0, 1'b1, 12'h002, 8'd6, 16'h1234, 1'b0, 1'b0, "out byte down wrap");
      run_xfer(1'b0, 2'd3, 1'b1, 12'h004, 8'd3, 16'h8001, 1'b1, 1'b0, "in rsvd size wrap");
      run_xfer(1'b1, 2'd1, 1'b0, 12'hFFE, 8'd2, 16'h0080, 1'b0, 1'b0, "out word up wrap");
      run_xfer(1'b0, 2'd2, 1'b0, 12'h040, 8'd4, 16'h0061, 1'b1, 1'b1, "in dword poke");
      run_xfer(1'b1, 2'd0, 1'b0, 12'h777, 8'd1, 16'h00AA, 1'b0, 1'b0, "out single");
      t_zero(12'hFFF);
      finish_run();
   end

endmodule